// File: doc/BRIEF.md
# Delay-Line Differential Phase Detector

This block measures how far the carrier phase has turned from one PSK symbol to the next, without a local oscillator. Every accepted audio sample is multiplied by two earlier samples of the same stream: one taken slightly less than a symbol period back (the cosine tap) and one taken slightly more than a symbol period back (the sine tap). Both product streams pass through a moving-sum lowpass filter of programmable length. The filtered pair (I, Q) is then reduced to a phase-change index for every sample. A clock-recovery stage further down the chain picks the index at the symbol centres.

Two modes are supported. Four-phase mode sends two bits per symbol and uses taps at 11/12 and 13/12 of a symbol. Eight-phase mode sends three bits per symbol and uses taps at 8/9 and 10/9 of a symbol. Each tap is rounded to whole samples. The delay line is 1.25 symbols long, so both taps fit in it. The symbol length in samples is a parameter for each mode: the carrier is fixed, so the symbol rate is the bit rate divided by the bits per symbol.

Samples enter and results leave on valid/ready streams. The whole pipeline moves as one unit. When a result is waiting and downstream does not take it, no stage advances and the input is not ready. A sample counts as transferred on a clock edge where in_valid and in_ready are both high. A result counts as transferred on a clock edge where out_valid and out_ready are both high. Mode and window length are configuration: they are set while reset is asserted and held afterwards.

Top module: `psk_delay_phase_det`

## Requirements
- R1: For the accepted sample x[n], the cosine product is x[n]*x[n-C] and the sine product is x[n]*x[n-S]. Samples from before reset count as zero. In four-phase mode C=round(11/12*P4) and S=round(13/12*P4); with the default P4=12 these are 11 and 13. In eight-phase mode C=round(8/9*P8) and S=round(10/9*P8); with the default P8=9 these are 8 and 10.
- R2: out_i is the sum of the last L cosine products and out_q is the sum of the last L sine products, where L = win_len + 1 (1 to 64). Both are signed.
- R3: In four-phase mode (mode_8psk=0), out_idx is decided by sign only: I>0 and Q>0 give 0; I>0 and Q<=0 give 1; I<=0 and Q>0 give 3; all other cases give 2.
- R4: In eight-phase mode, take the angle atan2(I,Q) (I as the ordinate, Q as the abscissa) and express it in 256 units per turn, modulo 256. Subtract 48 units modulo 256. out_idx is the result divided by 32, rounded down (0 to 7). So index 0 is centred on +I, index 2 on -Q, and index 6 on +Q.
- R5: When I and Q are both zero, the angle counts as zero. The index is then 6 in eight-phase mode and 2 in four-phase mode.
- R6: Each accepted sample yields exactly one result, in order. With no back-pressure, out_valid for a sample is high after the third rising edge, counting the edge that accepts the sample.
- R7: in_ready is low whenever out_valid is high and out_ready is low. During such a stall, out_idx, out_i and out_q stay unchanged.
- R8: After reset, out_valid is 0, in_ready is 1, and all sample and product history is zero.
- R9: mode_8psk and win_len are changed only while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_8psk | input | 1 | 0 = four-phase, 1 = eight-phase |
| win_len | input | LW (6) | Moving-sum length minus one |
| in_valid | input | 1 | Sample strobe |
| in_ready | output | 1 | Pipeline can take a sample |
| in_sample | input | SAMPLE_W (12) | Signed audio sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_idx | output | 3 | Phase-change index |
| out_i | output | SUM_W (30) | Filtered cosine correlation |
| out_q | output | SUM_W (30) | Filtered sine correlation |

## Verification
Two events can land on the same clock edge. A new sample can be offered while downstream holds off a finished result. The same edge can also be the one where the moving sum drops its oldest product and adds the newest. The bench drives in_valid and out_ready from independent pseudo-random streams, so stalls hit edges where a sample is being offered, for window lengths 1, 5, 7 and 64. It checks that no offered sample is accepted during a stall and that the held result does not change. It also compares every delivered result, in order, against sums and sectors that the bench computes from its own record of the accepted samples.

// File: rtl/psk_dpd_pkg.sv
`timescale 1ns/1ps
package psk_dpd_pkg;
  // Nearest-integer division for positive operands.
  function automatic int round_div(input int num, input int den);
    return (2 * num + den) / (2 * den);
  endfunction

  // Fraction bits of the tan(22.5 deg) constant used by the sector slicer.
  localparam int TAN_FRAC = 24;
endpackage

// File: rtl/psk_dpd_delay.sv
`timescale 1ns/1ps
module psk_dpd_delay
  import psk_dpd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SPS_QPSK = 12,
  parameter int SPS_8PSK = 9,
  localparam int PW = 2 * SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       mode_8psk,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       v1,
  output logic signed [PW-1:0]       prod_c,
  output logic signed [PW-1:0]       prod_s
);
  localparam int C4    = round_div(11 * SPS_QPSK, 12);
  localparam int S4    = round_div(13 * SPS_QPSK, 12);
  localparam int C8    = round_div(8 * SPS_8PSK, 9);
  localparam int S8    = round_div(10 * SPS_8PSK, 9);
  localparam int MAXS  = (SPS_QPSK > SPS_8PSK) ? SPS_QPSK : SPS_8PSK;
  localparam int DEPTH = (5 * MAXS + 3) / 4;

  // hist[k] holds the sample accepted k+1 transfers ago.
  logic signed [SAMPLE_W-1:0] hist [DEPTH];
  logic signed [SAMPLE_W-1:0] tap_c, tap_s;
  logic signed [PW-1:0]       pc_d, ps_d;

  assign tap_c = mode_8psk ? hist[C8-1] : hist[C4-1];
  assign tap_s = mode_8psk ? hist[S8-1] : hist[S4-1];
  assign pc_d  = PW'(in_sample) * PW'(tap_c);
  assign ps_d  = PW'(in_sample) * PW'(tap_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
      v1     <= 1'b0;
      prod_c <= '0;
      prod_s <= '0;
    end else if (adv) begin
      v1 <= in_valid;
      if (in_valid) begin
        hist[0] <= in_sample;
        for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
        prod_c <= pc_d;
        prod_s <= ps_d;
      end
    end
  end
endmodule

// File: rtl/psk_dpd_movsum.sv
`timescale 1ns/1ps
module psk_dpd_movsum #(
  parameter int PW = 24,
  parameter int LW = 6,
  localparam int SW    = PW + LW,
  localparam int DEPTH = 2 ** LW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 v_in,
  input  logic [LW-1:0]        win_len,
  input  logic signed [PW-1:0] prod,
  output logic                 v_out,
  output logic signed [SW-1:0] sum
);
  logic signed [PW-1:0] ring [DEPTH];
  logic [LW-1:0]        wptr, rptr;
  logic signed [SW-1:0] add_v, sub_v;

  // The entry written win_len+1 transfers ago leaves the window now.
  assign rptr  = wptr - win_len - LW'(1);
  assign add_v = SW'(prod);
  assign sub_v = SW'(ring[rptr]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ring[k] <= '0;
      wptr  <= '0;
      sum   <= '0;
      v_out <= 1'b0;
    end else if (adv) begin
      v_out <= v_in;
      if (v_in) begin
        ring[wptr] <= prod;
        wptr       <= wptr + LW'(1);
        sum        <= sum + add_v - sub_v;
      end
    end
  end

  // The magnitude can never exceed window length times the largest product.
  logic [SW-1:0] mag;
  logic [63:0]   lim;
  assign mag = sum[SW-1] ? SW'(-sum) : SW'(sum);
  assign lim = (64'(win_len) + 64'd1) << (PW - 2);

  p_sum_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    64'(mag) <= lim);
endmodule

// File: rtl/psk_dpd_slicer.sv
`timescale 1ns/1ps
module psk_dpd_slicer
  import psk_dpd_pkg::*;
#(
  parameter int SW = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 v_in,
  input  logic                 mode_8psk,
  input  logic signed [SW-1:0] si,
  input  logic signed [SW-1:0] sq,
  output logic                 out_valid,
  output logic [2:0]           out_idx,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q
);
  localparam longint unsigned TANQ = 64'($rtoi(0.41421356237309503 * (2.0 ** TAN_FRAC)));

  logic [SW-1:0] ai, aq;
  logic [63:0]   ai_sc, aq_sc, ai_tan, aq_tan;
  logic          near_q, near_i, both_zero, ipos, qpos;
  logic [2:0]    idx4, idx8;

  assign ai     = si[SW-1] ? SW'(-si) : SW'(si);
  assign aq     = sq[SW-1] ? SW'(-sq) : SW'(sq);
  assign ai_sc  = 64'(ai) << TAN_FRAC;
  assign aq_sc  = 64'(aq) << TAN_FRAC;
  assign ai_tan = TANQ * 64'(ai);
  assign aq_tan = TANQ * 64'(aq);
  // Within 22.5 degrees of the Q axis, or of the I axis.
  assign near_q    = ai_sc < aq_tan;
  assign near_i    = aq_sc < ai_tan;
  assign both_zero = (si == '0) && (sq == '0);
  assign ipos      = (si > 0);
  assign qpos      = (sq > 0);

  always_comb begin
    case ({ipos, qpos})
      2'b11:   idx4 = 3'd0;
      2'b10:   idx4 = 3'd1;
      2'b01:   idx4 = 3'd3;
      default: idx4 = 3'd2;
    endcase
  end

  always_comb begin
    if (both_zero)      idx8 = 3'd6;
    else if (near_q)    idx8 = qpos ? 3'd6 : 3'd2;
    else if (near_i)    idx8 = ipos ? 3'd0 : 3'd4;
    else begin
      case ({ipos, qpos})
        2'b11:   idx8 = 3'd7;
        2'b10:   idx8 = 3'd1;
        2'b01:   idx8 = 3'd5;
        default: idx8 = 3'd3;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (adv) begin
      out_valid <= v_in;
      if (v_in) begin
        out_idx <= mode_8psk ? idx8 : idx4;
        out_i   <= si;
        out_q   <= sq;
      end
    end
  end

  p_four_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mode_8psk) |-> (out_idx[2] == 1'b0));

  p_zero_angle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_i == '0 && out_q == '0) |-> (out_idx == (mode_8psk ? 3'd6 : 3'd2)));
endmodule

// File: rtl/psk_delay_phase_det.sv
`timescale 1ns/1ps
module psk_delay_phase_det #(
  parameter int SAMPLE_W = 12,
  parameter int SPS_QPSK = 12,
  parameter int SPS_8PSK = 9,
  parameter int MAX_WIN  = 64,
  localparam int LW    = $clog2(MAX_WIN),
  localparam int PW    = 2 * SAMPLE_W,
  localparam int SUM_W = PW + LW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_8psk,
  input  logic [LW-1:0]              win_len,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [2:0]                 out_idx,
  output logic signed [SUM_W-1:0]    out_i,
  output logic signed [SUM_W-1:0]    out_q
);
  logic                    adv, v1, v2c, v2s;
  logic signed [PW-1:0]    prod_c, prod_s;
  logic signed [SUM_W-1:0] sum_c, sum_s;

  // One stall signal freezes every stage together.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  psk_dpd_delay #(.SAMPLE_W(SAMPLE_W), .SPS_QPSK(SPS_QPSK), .SPS_8PSK(SPS_8PSK)) u_delay (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mode_8psk(mode_8psk),
    .in_valid(in_valid), .in_sample(in_sample),
    .v1(v1), .prod_c(prod_c), .prod_s(prod_s)
  );

  psk_dpd_movsum #(.PW(PW), .LW(LW)) u_sum_c (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(v1), .win_len(win_len),
    .prod(prod_c), .v_out(v2c), .sum(sum_c)
  );

  psk_dpd_movsum #(.PW(PW), .LW(LW)) u_sum_s (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(v1), .win_len(win_len),
    .prod(prod_s), .v_out(v2s), .sum(sum_s)
  );

  psk_dpd_slicer #(.SW(SUM_W)) u_slice (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(v2c), .mode_8psk(mode_8psk),
    .si(sum_c), .sq(sum_s),
    .out_valid(out_valid), .out_idx(out_idx), .out_i(out_i), .out_q(out_q)
  );

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_i) && $stable(out_q)));

  p_sum_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v2c == v2s);

  p_cfg_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_8psk) && $stable(win_len));
endmodule

// File: tb/sim_psk_delay_phase_det.sv
`timescale 1ns/1ps
module sim_psk_delay_phase_det;
  localparam int W = 12, LW = 6, SW = 2 * W + LW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n, mode_8psk, in_valid, in_ready, out_valid, out_ready;
  logic [LW-1:0]        win_len;
  logic signed [W-1:0]  in_sample;
  logic [2:0]           out_idx;
  logic signed [SW-1:0] out_i, out_q;

  psk_delay_phase_det u0 (
    .clk(clk), .rst_n(rst_n), .mode_8psk(mode_8psk), .win_len(win_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_i(out_i), .out_q(out_q)
  );

  int total = 0, bad = 0;
  int xs [0:4095];
  int nacc, nout, cur_mode, cur_len;
  int unsigned rs = 32'h1234_5678;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d (mode=%0d L=%0d out#%0d)", req, act, exp, cur_mode, cur_len, nout);
    end
  endtask

  function automatic int unsigned rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic int gen_sample(input int n);
    int unsigned r;
    r = rnd();
    if ((n % 97) >= 75) return 0;
    if ((n % 53) == 7)  return -2048;
    if ((n % 59) == 11) return 2047;
    return int'(r % 81) - 40;
  endfunction

  // R1: product of sample m and the one d transfers earlier.
  function automatic int prod(input int m, input int d);
    if (m < 0 || m - d < 0) return 0;
    return xs[m] * xs[m-d];
  endfunction

  // R2: moving sum over the last L products.
  function automatic int msum(input int n, input int d);
    int s = 0;
    for (int j = 0; j < cur_len; j++) s += prod(n - j, d);
    return s;
  endfunction

  function automatic int ref_idx(input int i, input int q);
    real th;
    int  id, k;
    if (cur_mode == 0) begin
      if (i > 0) return (q > 0) ? 0 : 1;   // R3
      return (q > 0) ? 3 : 2;
    end
    th = (i == 0 && q == 0) ? 0.0 : $atan2(real'(i), real'(q));   // R4, R5
    id = $rtoi((th / (2.0 * 3.14159265358979323846) + 1.0) * 256.0) % 256;
    k  = id - 48;
    if (k < 0) k += 256;
    return k / 32;
  endfunction

  task automatic do_reset(input int mode, input int len);
    cur_mode  = mode;
    cur_len   = len;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    out_ready = 1'b1;
    @(negedge clk);
    mode_8psk = mode[0];            // R9: configuration moves only in reset
    win_len   = LW'(len - 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 out_valid after reset", out_valid, 0);
    chk("R8 in_ready after reset", in_ready, 1);
    nacc = 0;
    nout = 0;
  endtask

  task automatic run_cfg(input int mode, input int len, input int nsamp);
    logic [2:0]           h_idx;
    logic signed [SW-1:0] h_i, h_q;
    bit                   held = 0;
    int                   ei, eq, ex;
    do_reset(mode, len);
    while (nout < nsamp) begin
      @(negedge clk);
      if (held) begin
        chk("R7 idx held in stall", out_idx, h_idx);
        chk("R7 I held in stall", out_i, h_i);
        chk("R7 Q held in stall", out_q, h_q);
      end
      if (nacc < nsamp) begin
        in_valid  = (rnd() % 4) != 0;
        in_sample = W'(gen_sample(nacc));
        out_ready = (rnd() % 4) != 0;
      end else begin
        in_valid  = 1'b0;
        out_ready = 1'b1;
      end
      #1;
      held = 0;
      if (out_valid && !out_ready) begin
        chk("R7 no intake while stalled", in_ready, 0);
        h_idx = out_idx; h_i = out_i; h_q = out_q;
        held  = 1;
      end
      if (out_valid && out_ready) begin
        ei = msum(nout, (mode == 0) ? 11 : 8);
        eq = msum(nout, (mode == 0) ? 13 : 10);
        ex = ref_idx(ei, eq);
        chk("R1/R2 I sum", longint'(out_i), ei);
        chk("R1/R2 Q sum", longint'(out_q), eq);
        if (ei == 0 && eq == 0) chk("R5 zero angle", out_idx, ex);
        else if (mode == 0)     chk("R3 sign quadrant", out_idx, ex);
        else                    chk("R4 octant sector", out_idx, ex);
        nout++;
      end
      if (in_valid && in_ready) begin
        xs[nacc] = int'(in_sample);
        nacc++;
      end
    end
    chk("R6 one result per sample", nout, nacc);
  endtask

  task automatic latency_test();
    int k;
    do_reset(0, 1);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = W'(5);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    k = 1;
    while (!out_valid && k < 10) begin
      @(negedge clk);
      k++;
    end
    chk("R6 latency edges", k, 3);
    chk("R5 first sample has no history", out_idx, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    latency_test();
    run_cfg(0, 1, 400);
    run_cfg(0, 5, 400);
    run_cfg(0, 64, 400);
    run_cfg(1, 1, 400);
    run_cfg(1, 7, 400);
    run_cfg(1, 64, 400);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule